// File: doc/BRIEF.md
# Break Entry Stack Sequencer

This block carries out the entry half of a software break on a processor with an 8-bit stack that lives in one fixed page of memory. When a start pulse arrives while it is idle, it captures the current program counter, the current status byte and a 16-bit target vector. Over the next three clocks it pushes three bytes through a byte-wide memory write port: the low byte of the program counter, then the high byte, then a copy of the status byte in which the break bit is raised.

Each write lands at the stack page joined with the stack pointer. The pointer steps down by one after every write and wraps inside the page. Once the third byte is written, the block raises the interrupt-disable flag in its own copy of the status, moves the vector into its program counter output and pulses done for one clock. The surrounding core reads the new program counter, status and stack pointer from the outputs. Fetching the vector from memory and the return path are handled elsewhere.

Top module: `brk_entry_seq`

## Requirements
- R1: While reset is held and in the first cycle after it: `sp_o` is 0xFF, `pc_o` is 0x0000, `flags_o` is 0x20, and `busy_o`, `done_o` and `mem_we_o` are all low.
- R2: A start pulse seen at a clock edge while idle makes `busy_o` and `mem_we_o` high for exactly the next three cycles.
- R3: The three writes carry, in this order, `pc_i[7:0]`, then `pc_i[15:8]`, then the status byte, all taken from the values present at the start edge.
- R4: Each write goes to address `{8'h01, sp}`, where sp is the pointer value before that write, and the pointer drops by one after each write, for a net drop of three per entry.
- R5: The stack pointer wraps from 0x00 to 0xFF and stays inside page 0x01.
- R6: The status layout is N,V,1,B,D,I,Z,C from bit 7 down to bit 0. The pushed status byte equals the captured status with bit 4 (break) and bit 5 forced to 1 and every other bit unchanged.
- R7: In the cycle after the third write, `pc_o` equals the captured vector and `flags_o` equals the captured status with bit 2 (interrupt disable) and bit 5 set and bit 4 cleared.
- R8: `done_o` is high for exactly one cycle, the cycle right after the third write, and `busy_o` is low in that cycle.
- R9: A start pulse while busy is ignored. The bytes written, the vector loaded and the number of writes are all unchanged by it.
- R10: While idle, `mem_we_o` is low and `sp_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request to begin the break entry sequence |
| pc_i | input | 16 | Program counter to save |
| status_i | input | 8 | Status byte to save |
| vector_i | input | 16 | Target address loaded after the pushes |
| mem_addr_o | output | 16 | Stack write address |
| mem_wdata_o | output | 8 | Stack write data |
| mem_we_o | output | 1 | Stack write enable |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse after the last push |
| pc_o | output | 16 | Program counter after entry |
| flags_o | output | 8 | Status after entry |
| sp_o | output | 8 | Current stack pointer |

## Verification
The bench builds the block with its default parameters: a 16-bit program counter, an 8-bit stack pointer, stack page 0x01 and a reset pointer of 0xFF. With these values, each entry lowers the pointer by three. A few hundred back-to-back entries therefore drive it through 0x00 and on to 0xFF several times, so the wrap is covered. Because the status byte is a full 8 bits, the random values and the directed all-zero and all-one patterns show that only bits 4, 5 and 2 are changed.

// File: rtl/brk_pkg.sv
package brk_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LO   = 2'd1,
        PH_HI   = 2'd2,
        PH_SR   = 2'd3
    } phase_e;

    localparam int FLAG_I_POS = 2;
    localparam int FLAG_B_POS = 4;
    localparam int FLAG_U_POS = 5;
endpackage

// File: rtl/brk_status_fmt.sv
module brk_status_fmt #(
    parameter int W = 8
) (
    input  logic [W-1:0] sr_i,
    output logic [W-1:0] push_o,
    output logic [W-1:0] commit_o
);
    import brk_pkg::*;

    always_comb begin
        push_o                 = sr_i;
        push_o[FLAG_B_POS]     = 1'b1;
        push_o[FLAG_U_POS]     = 1'b1;
        commit_o               = sr_i;
        commit_o[FLAG_B_POS]   = 1'b0;
        commit_o[FLAG_U_POS]   = 1'b1;
        commit_o[FLAG_I_POS]   = 1'b1;
    end
endmodule

// File: rtl/brk_byte_sel.sv
module brk_byte_sel #(
    parameter int PC_W = 16,
    localparam int BW  = PC_W / 2
) (
    input  brk_pkg::phase_e phase_i,
    input  logic [PC_W-1:0] pc_i,
    input  logic [BW-1:0]   sr_i,
    output logic [BW-1:0]   byte_o
);
    import brk_pkg::*;

    always_comb begin
        unique case (phase_i)
            PH_LO:   byte_o = pc_i[BW-1:0];
            PH_HI:   byte_o = pc_i[PC_W-1:BW];
            PH_SR:   byte_o = sr_i;
            default: byte_o = '0;
        endcase
    end
endmodule

// File: rtl/brk_entry_seq.sv
module brk_entry_seq #(
    parameter int                    PC_W       = 16,
    parameter int                    SP_W       = 8,
    parameter logic [PC_W-SP_W-1:0]  STACK_PAGE = 'h01,
    parameter logic [SP_W-1:0]       SP_RESET   = '1,
    localparam int                   BW         = PC_W / 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [PC_W-1:0] pc_i,
    input  logic [BW-1:0]   status_i,
    input  logic [PC_W-1:0] vector_i,
    output logic [PC_W-1:0] mem_addr_o,
    output logic [BW-1:0]   mem_wdata_o,
    output logic            mem_we_o,
    output logic            busy_o,
    output logic            done_o,
    output logic [PC_W-1:0] pc_o,
    output logic [BW-1:0]   flags_o,
    output logic [SP_W-1:0] sp_o
);
    import brk_pkg::*;

    localparam logic [BW-1:0] FLAGS_RST = BW'(1) << FLAG_U_POS;

    typedef struct packed {
        phase_e          phase;
        logic [SP_W-1:0] sp;
        logic [PC_W-1:0] cap_pc;
        logic [BW-1:0]   cap_sr;
        logic [PC_W-1:0] cap_vec;
        logic [PC_W-1:0] pc;
        logic [BW-1:0]   flags;
        logic            done;
    } seq_t;

    seq_t            st_d, st_q;
    logic [BW-1:0]   sr_push, sr_commit;

    brk_status_fmt #(.W(BW)) u_fmt (
        .sr_i     (st_q.cap_sr),
        .push_o   (sr_push),
        .commit_o (sr_commit)
    );

    brk_byte_sel #(.PC_W(PC_W)) u_sel (
        .phase_i (st_q.phase),
        .pc_i    (st_q.cap_pc),
        .sr_i    (sr_push),
        .byte_o  (mem_wdata_o)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    st_d.phase   = PH_LO;
                    st_d.cap_pc  = pc_i;
                    st_d.cap_sr  = status_i;
                    st_d.cap_vec = vector_i;
                end
            end
            PH_LO: begin
                st_d.phase = PH_HI;
                st_d.sp    = st_q.sp - SP_W'(1);
            end
            PH_HI: begin
                st_d.phase = PH_SR;
                st_d.sp    = st_q.sp - SP_W'(1);
            end
            PH_SR: begin
                st_d.phase = PH_IDLE;
                st_d.sp    = st_q.sp - SP_W'(1);
                st_d.pc    = st_q.cap_vec;
                st_d.flags = sr_commit;
                st_d.done  = 1'b1;
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.phase   <= PH_IDLE;
            st_q.sp      <= SP_RESET;
            st_q.cap_pc  <= '0;
            st_q.cap_sr  <= '0;
            st_q.cap_vec <= '0;
            st_q.pc      <= '0;
            st_q.flags   <= FLAGS_RST;
            st_q.done    <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o     = (st_q.phase != PH_IDLE);
    assign mem_we_o   = busy_o;
    assign mem_addr_o = {STACK_PAGE, st_q.sp};
    assign done_o     = st_q.done;
    assign pc_o       = st_q.pc;
    assign flags_o    = st_q.flags;
    assign sp_o       = st_q.sp;
endmodule

// File: rtl/brk_entry_seq_chk.sv
module brk_entry_seq_chk #(
    parameter int SP_W = 8,
    parameter int BW   = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            mem_we_o,
    input logic [BW-1:0]   mem_wdata_o,
    input logic            busy_o,
    input logic            done_o,
    input logic [BW-1:0]   flags_o,
    input logic [SP_W-1:0] sp_o
);
    // R4 and R5: the pointer steps down by one after each write, wrapping in SP_W bits
    p_sp_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |=> sp_o == $past(sp_o) - SP_W'(1));

    p_sp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_o |=> $stable(sp_o));

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_done_after_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($past(mem_we_o) && !busy_o));

    p_brk_bit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($past(mem_wdata_o[4]) && $past(mem_wdata_o[5])));

    p_flags_commit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (flags_o[2] && !flags_o[4] && flags_o[5]));
endmodule

bind brk_entry_seq brk_entry_seq_chk #(.SP_W(SP_W), .BW(BW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mem_we_o    (mem_we_o),
    .mem_wdata_o (mem_wdata_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .flags_o     (flags_o),
    .sp_o        (sp_o)
);

// File: tb/sim_brk_entry_seq.sv
`timescale 1ns/1ps
module sim_brk_entry_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [15:0] pc_i = '0;
    logic [7:0]  status_i = '0;
    logic [15:0] vector_i = '0;
    logic [15:0] mem_addr_o;
    logic [7:0]  mem_wdata_o;
    logic        mem_we_o, busy_o, done_o;
    logic [15:0] pc_o;
    logic [7:0]  flags_o;
    logic [7:0]  sp_o;

    int checks = 0;
    int fails  = 0;
    logic [7:0] sp_m = 8'hFF;

    always #2.5 clk = ~clk;

    brk_entry_seq u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .pc_i(pc_i),
        .status_i(status_i), .vector_i(vector_i), .mem_addr_o(mem_addr_o),
        .mem_wdata_o(mem_wdata_o), .mem_we_o(mem_we_o), .busy_o(busy_o),
        .done_o(done_o), .pc_o(pc_o), .flags_o(flags_o), .sp_o(sp_o)
    );

    function automatic logic [7:0] pushed_sr(input logic [7:0] s);
        return s | 8'h30;
    endfunction

    function automatic logic [7:0] committed_sr(input logic [7:0] s);
        return (s & 8'hEF) | 8'h24;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_entry(input logic [15:0] pc, input logic [7:0] sr,
                            input logic [15:0] vec, input bit noisy);
        logic [7:0] exp_b;
        @(negedge clk);
        start_i = 1'b1; pc_i = pc; status_i = sr; vector_i = vec;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            exp_b = (k == 0) ? pc[7:0] : (k == 1) ? pc[15:8] : pushed_sr(sr);
            chk(mem_we_o && busy_o, "R2 write enable", {30'd0, busy_o, mem_we_o}, 32'h3);
            chk(mem_addr_o == {8'h01, sp_m}, (sp_m == 8'h00) ? "R5 address" : "R4 address",
                mem_addr_o, {8'h01, sp_m});
            chk(mem_wdata_o == exp_b, (k == 2) ? "R6 status byte" : "R3 byte order",
                mem_wdata_o, exp_b);
            sp_m = sp_m - 8'd1;
            if (noisy) begin
                start_i = $urandom_range(0, 1);
                pc_i = 16'($urandom); status_i = 8'($urandom); vector_i = 16'($urandom);
            end else begin
                start_i = 1'b0;
            end
        end
        @(negedge clk);
        start_i = 1'b0;
        chk(done_o && !busy_o && !mem_we_o, "R8 done cycle",
            {29'd0, done_o, busy_o, mem_we_o}, 32'h4);
        chk(pc_o == vec, noisy ? "R9 vector kept" : "R7 pc load", pc_o, vec);
        chk(flags_o == committed_sr(sr), "R7 flags", flags_o, committed_sr(sr));
        chk(sp_o == sp_m, "R4 pointer", sp_o, sp_m);
        @(negedge clk);
        chk(!done_o, "R8 done pulse width", done_o, 0);
        chk(!mem_we_o && sp_o == sp_m, noisy ? "R9 no extra write" : "R10 idle",
            {23'd0, mem_we_o, sp_o}, {24'd0, sp_m});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL R2 watchdog expired actual=hung expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        // R1 during reset
        chk(sp_o == 8'hFF && pc_o == 16'h0 && flags_o == 8'h20, "R1 reset regs",
            {pc_o, flags_o, sp_o}, 32'h000020FF);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy_o && !done_o && !mem_we_o, "R1 reset controls",
            {29'd0, busy_o, done_o, mem_we_o}, 0);
        chk(sp_o == 8'hFF, "R1 pointer after reset", sp_o, 8'hFF);

        do_entry(16'h0000, 8'h00, 16'hFFFE, 1'b0);
        do_entry(16'hFFFF, 8'hFF, 16'h0000, 1'b0);
        do_entry(16'h8001, 8'h10, 16'h1234, 1'b1);
        do_entry(16'h7F80, 8'hCB, 16'hFFFF, 1'b1);

        for (int n = 0; n < 300; n++) begin
            int gap;
            do_entry(16'($urandom), 8'($urandom), 16'($urandom), bit'($urandom_range(0, 1)));
            gap = $urandom_range(0, 3);
            for (int g = 0; g < gap; g++) begin
                @(negedge clk);
                chk(!mem_we_o && sp_o == sp_m, "R10 idle hold",
                    {23'd0, mem_we_o, sp_o}, {24'd0, sp_m});
            end
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule